// File: doc/BRIEF.md
# Polyphase FIR Resampler with Interpolated Coefficients

This block produces one stereo output sample for each job it is given. A job supplies a start address in an external sample RAM, a 20-bit fractional phase that places the wanted output between two stored input samples, and a rate factor. The block runs a single convolution over the stored samples. For each tap it derives the coefficient on the fly, by linear interpolation between entries of a sparse table that holds a smooth low-pass kernel. The effect is a filter with 2^20 phases, but only a few hundred coefficients are stored and only real input samples are multiplied.

When the input rate is above the output rate, the rate factor is below unity. The block then walks the kernel in smaller steps. This stretches the filter over more taps, which lowers its cutoff, and it scales each coefficient by the same factor so that the gain stays constant. The length of the stretched filter is capped by the depth of the sample RAM.

The left channel is processed first and the right channel second, through one multiply-accumulate path at one tap per clock. The surrounding logic measures the rate and the phase and fills the sample RAM.

Top module: `poly_resampler`

## Requirements
- R1: After synchronous reset, `out_left` and `out_right` are 0, and `done` and `smp_rd_en` are low.
- R2: A `start` is accepted only while the block is idle. Idle begins in the cycle after the `done` pulse. A `start` given while busy has no effect on the job in progress or on its results, and it produces no additional `done`.
- R3: The sample RAM read protocol works as follows:
  - Tap k of a channel reads address (start_addr − k) modulo 2^ADDR_W.
  - `smp_rd_right` is 1 for the right channel.
  - Read data is expected one clock after `smp_rd_en`.
  - At a unity rate factor, each channel uses exactly TAPS (64) reads.
- R4: The kernel table has TAPS·4+1 entries, with entry i = floor(4·2^(COEF_W−2)·i·(D−i)/D²), where D = TAPS·4. The tap coefficient is computed as follows:
  - The tap position p is a 26-bit value.
  - idx is p[25:18] and f is p[17:0].
  - The coefficient is c = e[idx] + floor((e[idx+1] − e[idx])·f / 2^18).
- R5: The rate factor r uses 12 fractional bits, so 4096 means 1.0, and any value above 4096 is treated as 4096. The position of tap k is floor((phase·r + k·r·2^20)/4096). The coefficient used is floor(c·r/4096).
- R6: A channel ends after the tap whose next position would reach TAPS·2^20, or after 2^ADDR_W taps, whichever comes first.
- R7: The result is the sum of sample × coefficient, shifted arithmetically right by COEF_W−2 and saturated to the signed DATA_W range.
- R8: All left-channel reads come before the right-channel reads of a job. `done` is a one-cycle pulse issued once both results are valid. `out_left` and `out_right` hold their values until the next job updates them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Job request, sampled while idle |
| start_addr | input | ADDR_W | Sample RAM address of the newest input sample |
| phase | input | PHASE_W | Fractional position between input samples |
| ratio | input | RATIO_FRAC+1 | Rate factor, 1.0 = 2^RATIO_FRAC |
| smp_rd_en | output | 1 | Sample RAM read strobe |
| smp_rd_addr | output | ADDR_W | Sample RAM read address |
| smp_rd_right | output | 1 | Channel select for the read (1 = right) |
| smp_rd_data | input | DATA_W | Signed sample, one cycle after the strobe |
| out_left | output | DATA_W | Signed left result |
| out_right | output | DATA_W | Signed right result |
| done | output | 1 | One-cycle pulse when both results are valid |

## Verification
A wrong tap position, interpolation fraction or table index changes the result of every later tap. It therefore shows up as a wrong `out_left` at the end of the same job, roughly TAPS/r + 5 cycles after `start`. Errors in the stretch or cap logic appear earlier, on the read strobe: the number of reads per channel differs from 64, from the stretched count, or from the RAM depth. A latched parameter that changes when `start` arrives during a busy job shows up at once in the results of that same job. Saturation faults only appear on full-scale inputs, and the directed scenarios with constant ±30000 samples expose them.

// File: rtl/rsmp_pkg.sv
`timescale 1ns/1ps
package rsmp_pkg;
  // Control tag that travels with each issued tap through the datapath
  typedef struct packed {
    logic valid;
    logic right;
    logic first;
    logic last;
  } tap_tag_t;
endpackage

// File: rtl/rsmp_coef_rom.sv
`timescale 1ns/1ps
module rsmp_coef_rom #(
  parameter int COEF_W = 16,
  parameter int IDX_W  = 8
) (
  input  logic                     clk,
  input  logic                     en,
  input  logic [IDX_W-1:0]         idx,
  output logic signed [COEF_W-1:0] c_lo,
  output logic signed [COEF_W-1:0] c_hi
);
  localparam int N    = (1 << IDX_W) + 1;
  localparam int SPAN = N - 1;
  localparam longint CMAX = longint'(1) << (COEF_W - 2);

  logic signed [COEF_W-1:0] table_q [N];

  function automatic logic signed [COEF_W-1:0] kernel_at(input int i);
    longint v;
    v = (longint'(i) * longint'(SPAN - i) * 4 * CMAX) / (longint'(SPAN) * longint'(SPAN));
    return COEF_W'(v);
  endfunction

  initial begin
    for (int i = 0; i < N; i++) table_q[i] = kernel_at(i);
  end

  logic [IDX_W:0] a_lo, a_hi;
  assign a_lo = {1'b0, idx};
  assign a_hi = a_lo + 1'b1;

  always_ff @(posedge clk) begin
    if (en) begin
      c_lo <= table_q[a_lo];
      c_hi <= table_q[a_hi];
    end
  end
endmodule

// File: rtl/rsmp_tap_seq.sv
`timescale 1ns/1ps
module rsmp_tap_seq
  import rsmp_pkg::*;
#(
  parameter int PHASE_W    = 20,
  parameter int TAPS       = 64,
  parameter int SUB_LOG    = 2,
  parameter int RATIO_FRAC = 12,
  parameter int ADDR_W     = 9,
  localparam int TAPS_LOG  = $clog2(TAPS),
  localparam int IDX_W     = TAPS_LOG + SUB_LOG,
  localparam int FRAC_W    = PHASE_W - SUB_LOG,
  localparam int RATIO_W   = RATIO_FRAC + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [ADDR_W-1:0]  start_addr,
  input  logic [PHASE_W-1:0] phase,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               job_done,
  output logic               rd_en,
  output logic [ADDR_W-1:0]  rd_addr,
  output logic               rd_right,
  output logic [IDX_W-1:0]   rom_idx,
  output logic [FRAC_W-1:0]  rom_frac,
  output tap_tag_t           tag,
  output logic [RATIO_W-1:0] ratio_q
);
  localparam int POS_W   = TAPS_LOG + PHASE_W;
  localparam int ACC_A_W = POS_W + RATIO_FRAC + 1;
  localparam logic [RATIO_W-1:0] UNITY = RATIO_W'(1) << RATIO_FRAC;
  localparam logic [ACC_A_W-1:0] SPAN  = ACC_A_W'(TAPS) << (PHASE_W + RATIO_FRAC);
  localparam logic [ADDR_W-1:0]  K_MAX = '1;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_WAIT} seq_state_t;

  seq_state_t         state;
  logic               chan;
  logic [ADDR_W-1:0]  k;
  logic [ADDR_W-1:0]  base;
  logic [ACC_A_W-1:0] pos_acc, pos_init, pos_nxt, step;
  logic [POS_W-1:0]   pos;
  logic [RATIO_W-1:0] ratio_c;
  logic               last_tap, busy;

  assign busy     = (state != S_IDLE);
  assign ratio_c  = (ratio > UNITY) ? UNITY : ratio;
  assign step     = ACC_A_W'(ratio_q) << PHASE_W;
  assign pos_nxt  = pos_acc + step;
  assign pos      = POS_W'(pos_acc >> RATIO_FRAC);
  assign last_tap = (pos_nxt >= SPAN) || (k == K_MAX);

  assign rd_en    = (state == S_RUN);
  assign rd_addr  = base - k;
  assign rd_right = chan;
  assign rom_idx  = pos[POS_W-1:FRAC_W];
  assign rom_frac = pos[FRAC_W-1:0];
  assign tag      = '{valid: rd_en, right: chan, first: (k == '0), last: last_tap};

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      chan     <= 1'b0;
      k        <= '0;
      base     <= '0;
      pos_acc  <= '0;
      pos_init <= '0;
      ratio_q  <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          ratio_q  <= ratio_c;
          base     <= start_addr;
          pos_init <= ACC_A_W'(phase) * ACC_A_W'(ratio_c);
          pos_acc  <= ACC_A_W'(phase) * ACC_A_W'(ratio_c);
          k        <= '0;
          chan     <= 1'b0;
          state    <= S_RUN;
        end
        S_RUN: begin
          if (last_tap) begin
            k       <= '0;
            pos_acc <= pos_init;
            if (chan) state <= S_WAIT;
            else      chan  <= 1'b1;
          end else begin
            k       <= k + 1'b1;
            pos_acc <= pos_nxt;
          end
        end
        S_WAIT: if (job_done) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R3: consecutive taps of one channel walk the sample RAM downwards
  assert_addr_step_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !tag.first) |-> (rd_addr == $past(rd_addr) - 1'b1));
  // R2: a start while busy leaves the latched job parameters alone
  assert_busy_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(ratio_q) && $stable(base) && $stable(pos_init)));
  // R2: a start while idle launches the first left tap next cycle
  assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (rd_en && tag.first && !rd_right));
endmodule

// File: rtl/rsmp_mac.sv
`timescale 1ns/1ps
module rsmp_mac
  import rsmp_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int COEF_W     = 16,
  parameter int FRAC_W     = 18,
  parameter int RATIO_FRAC = 12,
  parameter int GUARD      = 10,
  localparam int RATIO_W   = RATIO_FRAC + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  tap_tag_t                 tag_in,
  input  logic [FRAC_W-1:0]        frac_in,
  input  logic signed [COEF_W-1:0] c_lo,
  input  logic signed [COEF_W-1:0] c_hi,
  input  logic signed [DATA_W-1:0] smp,
  input  logic [RATIO_W-1:0]       ratio,
  output logic signed [DATA_W-1:0] out_left,
  output logic signed [DATA_W-1:0] out_right,
  output logic                     done
);
  localparam int CI_W    = COEF_W + 1;
  localparam int CE_W    = CI_W + 1;
  localparam int PROD_W  = DATA_W + CE_W;
  localparam int ACC_W   = PROD_W + GUARD;
  localparam int OUT_SH  = COEF_W - 2;
  localparam logic signed [ACC_W-1:0] SAT_HI = {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] SAT_LO = {{(ACC_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

  tap_tag_t tag_a, tag_b, tag_c, tag_d;
  logic [FRAC_W-1:0]          frac_a;
  logic signed [CI_W-1:0]     ci_b;
  logic signed [DATA_W-1:0]   smp_b, smp_c;
  logic signed [CE_W-1:0]     ce_c;
  logic signed [PROD_W-1:0]   prod_d;
  logic signed [ACC_W-1:0]    acc;

  logic signed [CI_W-1:0]          diff;
  logic signed [CI_W+FRAC_W:0]     blend;
  logic signed [CI_W-1:0]          ci_n;
  logic signed [CI_W+RATIO_W:0]    scaled;
  logic signed [CE_W-1:0]          ce_n;
  logic signed [ACC_W-1:0]         acc_n, acc_sh;

  // Stage B: linear interpolation between neighbouring table entries
  assign diff  = CI_W'(c_hi) - CI_W'(c_lo);
  assign blend = diff * $signed({1'b0, frac_a});
  assign ci_n  = CI_W'(c_lo) + CI_W'(blend >>> FRAC_W);
  // Stage C: gain compensation for the stretched filter
  assign scaled = ci_b * $signed({1'b0, ratio});
  assign ce_n   = CE_W'(scaled >>> RATIO_FRAC);
  // Stage E: accumulate and saturate
  assign acc_n  = tag_d.first ? ACC_W'(prod_d) : acc + ACC_W'(prod_d);
  assign acc_sh = acc_n >>> OUT_SH;

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_a <= '0;
      tag_b <= '0;
      tag_c <= '0;
      tag_d <= '0;
    end else begin
      tag_a <= tag_in;
      tag_b <= tag_a;
      tag_c <= tag_b;
      tag_d <= tag_c;
    end
  end

  always_ff @(posedge clk) begin
    frac_a <= frac_in;
    ci_b   <= ci_n;
    smp_b  <= smp;
    ce_c   <= ce_n;
    smp_c  <= smp_b;
    prod_d <= smp_c * ce_c;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      out_left  <= '0;
      out_right <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tag_d.valid) begin
        acc <= acc_n;
        if (tag_d.last) begin
          if (tag_d.right) begin
            out_right <= (acc_sh > SAT_HI) ? SAT_HI[DATA_W-1:0] :
                         (acc_sh < SAT_LO) ? SAT_LO[DATA_W-1:0] : acc_sh[DATA_W-1:0];
            done      <= 1'b1;
          end else begin
            out_left  <= (acc_sh > SAT_HI) ? SAT_HI[DATA_W-1:0] :
                         (acc_sh < SAT_LO) ? SAT_LO[DATA_W-1:0] : acc_sh[DATA_W-1:0];
          end
        end
      end
    end
  end

  // R4: an interpolated coefficient never leaves the span of its two entries
  assert_interp_bounds_R4: assert property (@(posedge clk) disable iff (rst)
    tag_b.valid |-> (((ci_b >= $past(c_lo)) && (ci_b <= $past(c_hi))) ||
                     ((ci_b <= $past(c_lo)) && (ci_b >= $past(c_hi)))));
  // R8: completion is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8: results only change on the closing tap of their channel
  assert_out_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !(tag_d.valid && tag_d.last) |=> ($stable(out_left) && $stable(out_right)));
endmodule

// File: rtl/poly_resampler.sv
`timescale 1ns/1ps
module poly_resampler
  import rsmp_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int COEF_W     = 16,
  parameter int PHASE_W    = 20,
  parameter int TAPS       = 64,
  parameter int SUB_LOG    = 2,
  parameter int RATIO_FRAC = 12,
  parameter int ADDR_W     = 9,
  parameter int GUARD      = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [ADDR_W-1:0]        start_addr,
  input  logic [PHASE_W-1:0]       phase,
  input  logic [RATIO_FRAC:0]      ratio,
  output logic                     smp_rd_en,
  output logic [ADDR_W-1:0]        smp_rd_addr,
  output logic                     smp_rd_right,
  input  logic signed [DATA_W-1:0] smp_rd_data,
  output logic signed [DATA_W-1:0] out_left,
  output logic signed [DATA_W-1:0] out_right,
  output logic                     done
);
  localparam int TAPS_LOG = $clog2(TAPS);
  localparam int IDX_W    = TAPS_LOG + SUB_LOG;
  localparam int FRAC_W   = PHASE_W - SUB_LOG;
  localparam int RATIO_W  = RATIO_FRAC + 1;

  logic [IDX_W-1:0]         rom_idx;
  logic [FRAC_W-1:0]        rom_frac;
  logic [RATIO_W-1:0]       ratio_q;
  tap_tag_t                 tag;
  logic signed [COEF_W-1:0] c_lo, c_hi;

  rsmp_tap_seq #(
    .PHASE_W(PHASE_W), .TAPS(TAPS), .SUB_LOG(SUB_LOG),
    .RATIO_FRAC(RATIO_FRAC), .ADDR_W(ADDR_W)
  ) seq_i (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .phase(phase), .ratio(ratio), .job_done(done),
    .rd_en(smp_rd_en), .rd_addr(smp_rd_addr), .rd_right(smp_rd_right),
    .rom_idx(rom_idx), .rom_frac(rom_frac), .tag(tag), .ratio_q(ratio_q)
  );

  rsmp_coef_rom #(.COEF_W(COEF_W), .IDX_W(IDX_W)) rom_i (
    .clk(clk), .en(smp_rd_en), .idx(rom_idx), .c_lo(c_lo), .c_hi(c_hi)
  );

  rsmp_mac #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W),
    .RATIO_FRAC(RATIO_FRAC), .GUARD(GUARD)
  ) mac_i (
    .clk(clk), .rst(rst), .tag_in(tag), .frac_in(rom_frac),
    .c_lo(c_lo), .c_hi(c_hi), .smp(smp_rd_data), .ratio(ratio_q),
    .out_left(out_left), .out_right(out_right), .done(done)
  );
endmodule

// File: tb/poly_resampler_tb.sv
`timescale 1ns/1ps
module poly_resampler_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [8:0]  start_addr = '0;
  logic [19:0] phase = '0;
  logic [12:0] ratio = '0;
  logic        smp_rd_en, smp_rd_right, done;
  logic [8:0]  smp_rd_addr;
  logic signed [15:0] smp_rd_data;
  logic signed [15:0] out_left, out_right;

  logic signed [15:0] mem_l [512];
  logic signed [15:0] mem_r [512];

  int checks = 0;
  int fails  = 0;
  int cnt_l  = 0;
  int cnt_r  = 0;
  int order_err = 0;
  bit seen_r = 1'b0;

  always #2 clk = ~clk;

  poly_resampler dut_i (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .phase(phase), .ratio(ratio), .smp_rd_en(smp_rd_en),
    .smp_rd_addr(smp_rd_addr), .smp_rd_right(smp_rd_right),
    .smp_rd_data(smp_rd_data), .out_left(out_left),
    .out_right(out_right), .done(done)
  );

  // Sample RAM model, one cycle read latency (R3)
  always @(posedge clk) begin
    if (smp_rd_en) smp_rd_data <= smp_rd_right ? mem_r[smp_rd_addr] : mem_l[smp_rd_addr];
  end

  // Read counting and left-before-right ordering (R8)
  always @(posedge clk) begin
    if (start && !smp_rd_en) seen_r <= 1'b0;
    else if (smp_rd_en) begin
      if (smp_rd_right) begin cnt_r <= cnt_r + 1; seen_r <= 1'b1; end
      else begin
        cnt_l <= cnt_l + 1;
        if (seen_r) order_err <= order_err + 1;
      end
    end
  end

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    report();
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint kern(input longint i);
    return (i * (256 - i) * 4 * 16384) / (256 * 256);
  endfunction

  function automatic longint model(input bit right, input int addr, input longint ph,
                                   input longint r_in, output int taps);
    longint r, a, pos, idx, f, c0, c1, ci, ce, s, acc, y;
    int k;
    r = (r_in > 4096) ? 4096 : r_in;
    a = ph * r; acc = 0; k = 0;
    while (1) begin
      pos = a >>> 12;
      idx = pos >>> 18;
      f   = pos & ((longint'(1) << 18) - 1);
      c0  = kern(idx); c1 = kern(idx + 1);
      ci  = c0 + (((c1 - c0) * f) >>> 18);
      ce  = (ci * r) >>> 12;
      s   = right ? longint'(mem_r[(addr - k) & 511]) : longint'(mem_l[(addr - k) & 511]);
      acc += s * ce;
      a += r << 20;
      k++;
      if (a >= (longint'(64) << 32) || k == 512) break;
    end
    taps = k;
    y = acc >>> 14;
    if (y > 32767) y = 32767;
    if (y < -32768) y = -32768;
    return y;
  endfunction

  task automatic fill_pattern;
    for (int i = 0; i < 512; i++) begin
      mem_l[i] = 16'(((i * 97 + 13) % 401 - 200) * 40);
      mem_r[i] = 16'(((i * 53 + 7) % 331 - 165) * 60);
    end
  endtask

  task automatic launch(input int a, input longint ph, input int r);
    @(negedge clk);
    start_addr = 9'(a); phase = 20'(ph); ratio = 13'(r); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 3000 && !ok; i++) begin
      if (done) ok = 1'b1;
      else @(negedge clk);
    end
  endtask

  task automatic job(input string req, input int a, input longint ph, input int r,
                     output int tl, output int tr);
    int l0, r0, ml, mr;
    longint yl, yr;
    bit ok;
    l0 = cnt_l; r0 = cnt_r;
    launch(a, ph, r);
    wait_done(ok);
    chk({req, " done"}, ok, 1);
    yl = model(1'b0, a, ph, r, ml);
    yr = model(1'b1, a, ph, r, mr);
    chk({req, " left"}, out_left, yl);
    chk({req, " right"}, out_right, yr);
    tl = cnt_l - l0; tr = cnt_r - r0;
    chk({req, " left taps"}, tl, ml);
    chk({req, " right taps"}, tr, mr);
    @(negedge clk);
    chk("R8 done pulse width", done, 0);
  endtask

  task automatic t_reset;
    chk("R1 out_left", out_left, 0);
    chk("R1 out_right", out_right, 0);
    chk("R1 done", done, 0);
    chk("R1 rd_en", smp_rd_en, 0);
  endtask

  task automatic t_unity;
    int tl, tr;
    fill_pattern();
    job("R3 R4 phase0", 10, 0, 4096, tl, tr);
    chk("R3 unity taps left", tl, 64);
    chk("R3 unity taps right", tr, 64);
    job("R4 half phase", 100, 20'h80000, 4096, tl, tr);
    job("R4 fine phase", 200, 20'h12345, 4096, tl, tr);
    job("R3 address wrap", 3, 20'hFFFFF, 4096, tl, tr);
  endtask

  task automatic t_decim;
    int tl, tr;
    job("R5 half rate", 300, 20'h40000, 2048, tl, tr);
    chk("R5 stretched taps", tl, 128);
    job("R5 odd rate", 50, 20'h0ABCD, 1500, tl, tr);
  endtask

  task automatic t_clamp;
    int tl, tr;
    longint l1, r1;
    job("R5 unity ref", 77, 20'h5A5A5, 4096, tl, tr);
    l1 = out_left; r1 = out_right;
    job("R5 clamp", 77, 20'h5A5A5, 7000, tl, tr);
    chk("R5 clamp left equals unity", out_left, l1);
    chk("R5 clamp right equals unity", out_right, r1);
    chk("R5 clamp taps", tl, 64);
  endtask

  task automatic t_cap;
    int tl, tr;
    job("R6 ram cap", 400, 20'h03000, 300, tl, tr);
    chk("R6 cap left", tl, 512);
    chk("R6 cap right", tr, 512);
  endtask

  task automatic t_sat;
    int tl, tr;
    for (int i = 0; i < 512; i++) begin mem_l[i] = 16'sd30000; mem_r[i] = -16'sd30000; end
    job("R7 saturate", 9, 20'h20000, 4096, tl, tr);
    chk("R7 positive clip", out_left, 32767);
    chk("R7 negative clip", out_right, -32768);
    fill_pattern();
  endtask

  task automatic t_busy;
    longint yl, yr, hl, hr;
    int ml, mr, extra;
    bit ok;
    launch(20, 20'h11111, 4096);
    repeat (5) @(negedge clk);
    launch(250, 20'h22222, 1024);
    wait_done(ok);
    chk("R2 first job done", ok, 1);
    yl = model(1'b0, 20, 20'h11111, 4096, ml);
    yr = model(1'b1, 20, 20'h11111, 4096, mr);
    chk("R2 left unaffected", out_left, yl);
    chk("R2 right unaffected", out_right, yr);
    hl = out_left; hr = out_right;
    extra = 0;
    repeat (300) begin @(negedge clk); if (done) extra++; end
    chk("R2 no extra done", extra, 0);
    chk("R8 left held", out_left, hl);
    chk("R8 right held", out_right, hr);
  endtask

  initial begin
    fill_pattern();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_unity();
    t_decim();
    t_clamp();
    t_cap();
    t_sat();
    t_busy();
    chk("R8 left before right", order_err, 0);
    report();
  end
endmodule